// File: doc/BRIEF.md
# Dual-Stack Interrupt and Status Controller

This block sits beside the fetch and execute logic of a small stack-oriented processor core. It holds the program counter, the processor status word, a data stack and a return stack. Each cycle it takes decoded control strobes and turns the winning one into stack pushes and pops, a program-counter load or a status update. The strobes are call, return, return-from-interrupt, byte-width toggle, status write, data push and data pop. Every operation finishes in a single clock.

An interrupt request is accepted only when the status interrupt-enable bit is set and no strobe is present in that cycle. On acceptance, the return address goes onto the return stack and the current status word goes onto the data stack in the same edge. The counter then jumps to a fixed vector. The handler starts with interrupts disabled and word-wide access. Return-from-interrupt pops both stacks at once and restores the counter and the status word. A plain return pops only the counter. The byte-mode bit of the status word is driven out as the access width for the load/store path.

Top module: `dualstack_ctrl`

## Requirements
- R1: While reset is low for at least one clock edge, the program counter, status word, both stack counts, both stack tops, all four error flags and the acknowledge are all zero.
- R2: A call pushes `ret_addr` onto the return stack and loads `call_target` into the program counter. The data stack and the status word are left unchanged.
- R3: A return loads the return-stack top into the program counter and pops the return stack. The data stack and the status word are left unchanged.
- R4: An accepted interrupt does all of the following in one edge: it pushes `ret_addr` onto the return stack, pushes the old status word onto the data stack, loads `IRQ_VECTOR` into the program counter, clears status bit 1 (interrupt enable) and sets status bit 0 (byte mode) to `BM_DEFAULT`. `irq_ack` is high for the cycle that follows.
- R5: A return-from-interrupt loads the return-stack top into the program counter and the data-stack top into the status word, and pops both stacks in the same edge.
- R6: The toggle strobe inverts status bit 0 and leaves all other status bits unchanged. `byte_mode` always equals status bit 0 (1 = byte access, 0 = word access).
- R7: The status write strobe loads the full `psw_wdata` value into the status word.
- R8: An interrupt is accepted only in a cycle where `irq_req` is high, status bit 1 is set and no strobe is present. A request that coincides with a strobe, for example a call, is taken at the next strobe-free cycle if it is still held.
- R9: When several strobes coincide, exactly one of them acts. Priority runs from highest to lowest: return-from-interrupt, return, call, status write, toggle, data push, data pop.
- R10: A push onto a stack that already holds 16 entries stores nothing and sets that stack's overflow flag. The flag stays set until reset.
- R11: A pop from an empty stack changes nothing on that stack and sets that stack's underflow flag, which stays set until reset. A return or return-from-interrupt with an empty return stack leaves the program counter unchanged. A return-from-interrupt with an empty data stack leaves the status word unchanged.
- R12: A data push stores `dpush_data` as the new data-stack top, and a data pop removes the top. The stack counts and stack tops (zero when a stack is empty) are visible at the ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Interrupt request, level |
| do_call | input | 1 | Call strobe |
| do_ret | input | 1 | Return strobe |
| do_reti | input | 1 | Return-from-interrupt strobe |
| do_bm_toggle | input | 1 | Byte-mode toggle strobe |
| do_psw_wr | input | 1 | Status word write strobe |
| psw_wdata | input | WIDTH | Value for status write |
| do_dpush | input | 1 | Data-stack push strobe |
| do_dpop | input | 1 | Data-stack pop strobe |
| dpush_data | input | WIDTH | Value for data push |
| ret_addr | input | WIDTH | Return address saved by call or interrupt |
| call_target | input | WIDTH | Destination of a call |
| pc_q | output | WIDTH | Program counter |
| psw_q | output | WIDTH | Status word |
| byte_mode | output | 1 | Memory access width, 1 = byte |
| irq_ack | output | 1 | Pulses the cycle after interrupt entry |
| ds_top | output | WIDTH | Data-stack top, zero when empty |
| rs_top | output | WIDTH | Return-stack top, zero when empty |
| ds_count | output | $clog2(DEPTH+1) | Data-stack entries |
| rs_count | output | $clog2(DEPTH+1) | Return-stack entries |
| ds_ovf | output | 1 | Sticky data-stack overflow |
| ds_unf | output | 1 | Sticky data-stack underflow |
| rs_ovf | output | 1 | Sticky return-stack overflow |
| rs_unf | output | 1 | Sticky return-stack underflow |

## Verification
The hardest state to reach from the ports is an interrupt that has been held off by a call and then lands on the following strobe-free cycle. That state needs the enable bit set first through a status write, and a request held across both cycles. A directed sequence builds exactly this case, then unwinds it with return-from-interrupt and return to show that both stacks restore. Random stimulus writes arbitrary status values, so the enable bit comes and goes. It also fires requests alongside every strobe mix, which drives interrupt entry against full and empty stacks and checks the result against a bench model of both stacks.

// File: rtl/dsc_pkg.sv
// Shared definitions for the dual-stack controller.
// Assumes status words are at least two bits wide.
package dsc_pkg;
    localparam int PSW_BM_BIT = 0;   // byte-mode flag position
    localparam int PSW_IE_BIT = 1;   // interrupt-enable position

    typedef enum logic [3:0] {
        OP_NONE,
        OP_CALL,
        OP_RET,
        OP_RETI,
        OP_IRQ,
        OP_PSWWR,
        OP_TOG,
        OP_DPUSH,
        OP_DPOP
    } op_e;
endpackage

// File: rtl/dsc_lifo.sv
// Register-based last-in first-out stack with a fill count.
// Does: one push or one pop per cycle (push wins if both), sticky
// overflow/underflow flags, combinational top (zero when empty).
// Assumes: a push on full and a pop on empty leave contents unchanged.
module dsc_lifo #(
    parameter int WIDTH = 16,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic                         pop,
    input  logic [WIDTH-1:0]             wdata,
    output logic [WIDTH-1:0]             top,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         ovf,
    output logic                         unf
);
    localparam int CW = $clog2(DEPTH+1);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [WIDTH-1:0] mem [DEPTH];
    logic             full;
    logic             empty;

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);

    // Storage write: the new entry lands just above the current top.
    always_ff @(posedge clk) begin
        if (push && !full) begin
            mem[AW'(count)] <= wdata;
        end
    end

    // Fill count and sticky error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
            unf   <= 1'b0;
        end else if (push) begin
            if (full) ovf <= 1'b1;
            else      count <= count + 1'b1;
        end else if (pop) begin
            if (empty) unf <= 1'b1;
            else       count <= count - 1'b1;
        end
    end

    // Top-of-stack read, forced to zero when nothing is stored.
    always_comb begin
        if (empty) top = '0;
        else       top = mem[AW'(count - 1'b1)];
    end
endmodule

// File: rtl/dsc_decode.sv
// Strobe arbiter: picks the single operation for this cycle.
// Does: fixed priority among strobes; an interrupt only when enabled
// and no strobe is present; derives push/pop controls per stack.
// Assumes: strobes are single-cycle decoded pulses.
module dsc_decode
    import dsc_pkg::*;
(
    input  logic irq_req,
    input  logic irq_en,
    input  logic do_call,
    input  logic do_ret,
    input  logic do_reti,
    input  logic do_bm_toggle,
    input  logic do_psw_wr,
    input  logic do_dpush,
    input  logic do_dpop,
    output op_e  op,
    output logic ds_push,
    output logic ds_pop,
    output logic rs_push,
    output logic rs_pop
);
    // Priority selection of the one operation that acts this cycle.
    always_comb begin
        if (do_reti)                op = OP_RETI;
        else if (do_ret)            op = OP_RET;
        else if (do_call)           op = OP_CALL;
        else if (do_psw_wr)         op = OP_PSWWR;
        else if (do_bm_toggle)      op = OP_TOG;
        else if (do_dpush)          op = OP_DPUSH;
        else if (do_dpop)           op = OP_DPOP;
        else if (irq_req && irq_en) op = OP_IRQ;
        else                        op = OP_NONE;
    end

    assign ds_push = (op == OP_IRQ)  || (op == OP_DPUSH);
    assign ds_pop  = (op == OP_RETI) || (op == OP_DPOP);
    assign rs_push = (op == OP_IRQ)  || (op == OP_CALL);
    assign rs_pop  = (op == OP_RETI) || (op == OP_RET);
endmodule

// File: rtl/dsc_psw.sv
// Processor status word register.
// Does: full write, byte-mode toggle, restore on return-from-interrupt,
// and on interrupt entry clears enable and forces the default width.
// Assumes: restore is skipped when the data stack holds nothing.
module dsc_psw
    import dsc_pkg::*;
#(
    parameter int   WIDTH      = 16,
    parameter logic BM_DEFAULT = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  op_e              op,
    input  logic [WIDTH-1:0] wdata,
    input  logic [WIDTH-1:0] restore_val,
    input  logic             restore_ok,
    output logic [WIDTH-1:0] psw
);
    // Status update for the selected operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psw <= '0;
        end else begin
            case (op)
                OP_RETI:  if (restore_ok) psw <= restore_val;
                OP_PSWWR: psw <= wdata;
                OP_TOG:   psw[PSW_BM_BIT] <= ~psw[PSW_BM_BIT];
                OP_IRQ: begin
                    psw[PSW_IE_BIT] <= 1'b0;
                    psw[PSW_BM_BIT] <= BM_DEFAULT;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dualstack_ctrl.sv
// Dual-stack interrupt and status controller (top).
// Does: owns program counter, status word, data and return stacks;
// executes one strobe per cycle; saves address and status in one edge
// on interrupt entry and restores both on return-from-interrupt.
// Assumes: ret_addr is the address following the current instruction.
module dualstack_ctrl
    import dsc_pkg::*;
#(
    parameter int               WIDTH      = 16,
    parameter int               DEPTH      = 16,
    parameter logic [WIDTH-1:0] IRQ_VECTOR = 'h10,
    parameter logic             BM_DEFAULT = 1'b0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       irq_req,
    input  logic                       do_call,
    input  logic                       do_ret,
    input  logic                       do_reti,
    input  logic                       do_bm_toggle,
    input  logic                       do_psw_wr,
    input  logic [WIDTH-1:0]           psw_wdata,
    input  logic                       do_dpush,
    input  logic                       do_dpop,
    input  logic [WIDTH-1:0]           dpush_data,
    input  logic [WIDTH-1:0]           ret_addr,
    input  logic [WIDTH-1:0]           call_target,
    output logic [WIDTH-1:0]           pc_q,
    output logic [WIDTH-1:0]           psw_q,
    output logic                       byte_mode,
    output logic                       irq_ack,
    output logic [WIDTH-1:0]           ds_top,
    output logic [WIDTH-1:0]           rs_top,
    output logic [$clog2(DEPTH+1)-1:0] ds_count,
    output logic [$clog2(DEPTH+1)-1:0] rs_count,
    output logic                       ds_ovf,
    output logic                       ds_unf,
    output logic                       rs_ovf,
    output logic                       rs_unf
);
    op_e              op;
    logic             ds_push, ds_pop, rs_push, rs_pop;
    logic [WIDTH-1:0] ds_wdata;

    dsc_decode u_decode (
        .irq_req      (irq_req),
        .irq_en       (psw_q[PSW_IE_BIT]),
        .do_call      (do_call),
        .do_ret       (do_ret),
        .do_reti      (do_reti),
        .do_bm_toggle (do_bm_toggle),
        .do_psw_wr    (do_psw_wr),
        .do_dpush     (do_dpush),
        .do_dpop      (do_dpop),
        .op           (op),
        .ds_push      (ds_push),
        .ds_pop       (ds_pop),
        .rs_push      (rs_push),
        .rs_pop       (rs_pop)
    );

    // Data stack receives the old status on interrupt entry.
    assign ds_wdata = (op == OP_IRQ) ? psw_q : dpush_data;

    dsc_lifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dstack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (ds_push),
        .pop   (ds_pop),
        .wdata (ds_wdata),
        .top   (ds_top),
        .count (ds_count),
        .ovf   (ds_ovf),
        .unf   (ds_unf)
    );

    dsc_lifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_rstack (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rs_push),
        .pop   (rs_pop),
        .wdata (ret_addr),
        .top   (rs_top),
        .count (rs_count),
        .ovf   (rs_ovf),
        .unf   (rs_unf)
    );

    dsc_psw #(.WIDTH(WIDTH), .BM_DEFAULT(BM_DEFAULT)) u_psw (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .wdata       (psw_wdata),
        .restore_val (ds_top),
        .restore_ok  (ds_count != '0),
        .psw         (psw_q)
    );

    assign byte_mode = psw_q[PSW_BM_BIT];

    // Program counter loads for flow-changing operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            case (op)
                OP_CALL:         pc_q <= call_target;
                OP_RET, OP_RETI: if (rs_count != '0) pc_q <= rs_top;
                OP_IRQ:          pc_q <= IRQ_VECTOR;
                default: ;
            endcase
        end
    end

    // Acknowledge pulse marking the cycle after interrupt entry.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_ack <= 1'b0;
        else        irq_ack <= (op == OP_IRQ);
    end
endmodule

// File: rtl/dsc_checker.sv
// Property checker for dualstack_ctrl, attached with bind.
// Does: checks reset state, interrupt entry, masking, stack stability
// on call and return, toggling and sticky error flags.
module dsc_checker
    import dsc_pkg::*;
#(
    parameter int               WIDTH      = 16,
    parameter int               DEPTH      = 16,
    parameter logic [WIDTH-1:0] IRQ_VECTOR = 'h10,
    parameter logic             BM_DEFAULT = 1'b0
) (
    input logic                       clk,
    input logic                       rst_n,
    input op_e                        op,
    input logic                       do_call,
    input logic                       do_ret,
    input logic                       do_reti,
    input logic                       do_bm_toggle,
    input logic                       do_psw_wr,
    input logic                       do_dpush,
    input logic                       do_dpop,
    input logic                       irq_ack,
    input logic [WIDTH-1:0]           pc_q,
    input logic [WIDTH-1:0]           psw_q,
    input logic [$clog2(DEPTH+1)-1:0] ds_count,
    input logic [$clog2(DEPTH+1)-1:0] rs_count,
    input logic                       ds_ovf,
    input logic                       ds_unf,
    input logic                       rs_ovf,
    input logic                       rs_unf
);
    localparam int CW = $clog2(DEPTH+1);
    logic any_strobe;
    assign any_strobe = do_call | do_ret | do_reti | do_bm_toggle |
                        do_psw_wr | do_dpush | do_dpop;

    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (pc_q == '0 && psw_q == '0 && ds_count == '0 &&
                    rs_count == '0 && !ds_ovf && !ds_unf && !rs_ovf &&
                    !rs_unf && !irq_ack));

    assert_irq_entry_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> (!psw_q[PSW_IE_BIT] && psw_q[PSW_BM_BIT] == BM_DEFAULT));

    assert_irq_vector_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> pc_q == IRQ_VECTOR);

    assert_strobe_blocks_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        any_strobe |=> !irq_ack);

    assert_masked_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !psw_q[PSW_IE_BIT] |=> !irq_ack);

    assert_ret_keeps_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RET) |=> ($stable(ds_count) && $stable(psw_q)));

    assert_call_keeps_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_CALL) |=> ($stable(ds_count) && $stable(psw_q)));

    assert_toggle_flips_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_TOG) |=> (psw_q[PSW_BM_BIT] != $past(psw_q[PSW_BM_BIT])));

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_count <= CW'(DEPTH)) && (rs_count <= CW'(DEPTH)));

    assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_ovf || rs_ovf) |=> (($past(ds_ovf) -> ds_ovf) && ($past(rs_ovf) -> rs_ovf)));

    assert_unf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ds_unf || rs_unf) |=> (($past(ds_unf) -> ds_unf) && ($past(rs_unf) -> rs_unf)));
endmodule

bind dualstack_ctrl dsc_checker #(
    .WIDTH(WIDTH), .DEPTH(DEPTH), .IRQ_VECTOR(IRQ_VECTOR), .BM_DEFAULT(BM_DEFAULT)
) u_dsc_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .op           (op),
    .do_call      (do_call),
    .do_ret       (do_ret),
    .do_reti      (do_reti),
    .do_bm_toggle (do_bm_toggle),
    .do_psw_wr    (do_psw_wr),
    .do_dpush     (do_dpush),
    .do_dpop      (do_dpop),
    .irq_ack      (irq_ack),
    .pc_q         (pc_q),
    .psw_q        (psw_q),
    .ds_count     (ds_count),
    .rs_count     (rs_count),
    .ds_ovf       (ds_ovf),
    .ds_unf       (ds_unf),
    .rs_ovf       (rs_ovf),
    .rs_unf       (rs_unf)
);

// File: tb/dualstack_ctrl_test.sv
// Bench for dualstack_ctrl: directed corner cases then seeded random
// stimulus, all compared against a behavioural model of both stacks.
module dualstack_ctrl_test;
    localparam int          CLK_PERIOD = 10;
    localparam int          W          = 16;
    localparam int          D          = 16;
    localparam int          CW         = $clog2(D+1);
    localparam logic [W-1:0] VEC       = 16'h0010;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq_req, do_call, do_ret, do_reti, do_bm_toggle;
    logic          do_psw_wr, do_dpush, do_dpop;
    logic [W-1:0]  psw_wdata, dpush_data, ret_addr, call_target;
    logic [W-1:0]  pc_q, psw_q, ds_top, rs_top;
    logic          byte_mode, irq_ack, ds_ovf, ds_unf, rs_ovf, rs_unf;
    logic [CW-1:0] ds_count, rs_count;

    dualstack_ctrl #(.WIDTH(W), .DEPTH(D), .IRQ_VECTOR(VEC), .BM_DEFAULT(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .do_call(do_call),
        .do_ret(do_ret), .do_reti(do_reti), .do_bm_toggle(do_bm_toggle),
        .do_psw_wr(do_psw_wr), .psw_wdata(psw_wdata), .do_dpush(do_dpush),
        .do_dpop(do_dpop), .dpush_data(dpush_data), .ret_addr(ret_addr),
        .call_target(call_target), .pc_q(pc_q), .psw_q(psw_q),
        .byte_mode(byte_mode), .irq_ack(irq_ack), .ds_top(ds_top),
        .rs_top(rs_top), .ds_count(ds_count), .rs_count(rs_count),
        .ds_ovf(ds_ovf), .ds_unf(ds_unf), .rs_ovf(rs_ovf), .rs_unf(rs_unf)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    // Behavioural model state
    logic [W-1:0] m_ds [D];
    logic [W-1:0] m_rs [D];
    int           m_dn, m_rn;
    logic [W-1:0] m_pc, m_psw;
    logic         m_dovf, m_dunf, m_rovf, m_runf, m_ack;

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic clear_in();
        irq_req = 0; do_call = 0; do_ret = 0; do_reti = 0; do_bm_toggle = 0;
        do_psw_wr = 0; do_dpush = 0; do_dpop = 0;
        psw_wdata = '0; dpush_data = '0; ret_addr = '0; call_target = '0;
    endtask

    task automatic model_reset();
        m_dn = 0; m_rn = 0; m_pc = '0; m_psw = '0;
        m_dovf = 0; m_dunf = 0; m_rovf = 0; m_runf = 0; m_ack = 0;
    endtask

    function automatic logic [W-1:0] dtop();
        return (m_dn == 0) ? '0 : m_ds[m_dn-1];
    endfunction
    function automatic logic [W-1:0] rtop();
        return (m_rn == 0) ? '0 : m_rs[m_rn-1];
    endfunction

    task automatic m_dpush(logic [W-1:0] v);
        if (m_dn == D) m_dovf = 1; else begin m_ds[m_dn] = v; m_dn++; end
    endtask
    task automatic m_rpush(logic [W-1:0] v);
        if (m_rn == D) m_rovf = 1; else begin m_rs[m_rn] = v; m_rn++; end
    endtask

    // Advance the model by one edge from the currently driven inputs;
    // returns the requirement tag of the operation that acts.
    task automatic model_step(output string tag);
        int n;
        n = do_call + do_ret + do_reti + do_bm_toggle + do_psw_wr + do_dpush + do_dpop;
        m_ack = 0;
        if (do_reti) begin
            tag = "R5";
            if (m_rn > 0) begin m_pc = m_rs[m_rn-1]; m_rn--; end else m_runf = 1;
            if (m_dn > 0) begin m_psw = m_ds[m_dn-1]; m_dn--; end else m_dunf = 1;
        end else if (do_ret) begin
            tag = "R3";
            if (m_rn > 0) begin m_pc = m_rs[m_rn-1]; m_rn--; end else m_runf = 1;
        end else if (do_call) begin
            tag = "R2";
            m_rpush(ret_addr); m_pc = call_target;
        end else if (do_psw_wr) begin
            tag = "R7"; m_psw = psw_wdata;
        end else if (do_bm_toggle) begin
            tag = "R6"; m_psw[0] = ~m_psw[0];
        end else if (do_dpush) begin
            tag = "R12"; m_dpush(dpush_data);
        end else if (do_dpop) begin
            tag = "R12";
            if (m_dn > 0) m_dn--; else m_dunf = 1;
        end else if (irq_req && m_psw[1]) begin
            tag = "R4";
            m_rpush(ret_addr); m_dpush(m_psw);
            m_psw[1] = 0; m_psw[0] = 0; m_pc = VEC; m_ack = 1;
        end else begin
            tag = "R8";
        end
        if (n > 1) tag = "R9";
    endtask

    task automatic compare_all(string tag);
        string ftag;
        chk(tag, "pc", 32'(pc_q), 32'(m_pc));
        chk(tag, "psw", 32'(psw_q), 32'(m_psw));
        chk("R6", "byte_mode", 32'(byte_mode), 32'(m_psw[0]));
        chk(tag, "ds_count", 32'(ds_count), 32'(m_dn));
        chk(tag, "rs_count", 32'(rs_count), 32'(m_rn));
        chk("R12", "ds_top", 32'(ds_top), 32'(dtop()));
        chk(tag, "rs_top", 32'(rs_top), 32'(rtop()));
        chk("R10", "ds_ovf", 32'(ds_ovf), 32'(m_dovf));
        chk("R10", "rs_ovf", 32'(rs_ovf), 32'(m_rovf));
        chk("R11", "ds_unf", 32'(ds_unf), 32'(m_dunf));
        chk("R11", "rs_unf", 32'(rs_unf), 32'(m_runf));
        ftag = m_ack ? "R4" : "R8";
        chk(ftag, "irq_ack", 32'(irq_ack), 32'(m_ack));
    endtask

    // One instruction cycle: model, edge, compare away from the edge.
    task automatic tick();
        string tag;
        model_step(tag);
        @(posedge clk);
        @(negedge clk);
        compare_all(tag);
        clear_in();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        clear_in();
        repeat (3) @(negedge clk);
        chk("R1", "pc", 32'(pc_q), 0);
        chk("R1", "psw", 32'(psw_q), 0);
        chk("R1", "counts", 32'({ds_count, rs_count}), 0);
        chk("R1", "tops", 32'({ds_top, rs_top}), 0);
        chk("R1", "flags", 32'({ds_ovf, ds_unf, rs_ovf, rs_unf, irq_ack}), 0);
        rst_n = 1;
        model_reset();
    endtask

    task automatic rand_cycle();
        int r;
        clear_in();
        r = int'($urandom % 20);
        case (r)
            0: do_call = 1;
            1: do_ret = 1;
            2: do_reti = 1;
            3: do_bm_toggle = 1;
            4: do_psw_wr = 1;
            5, 6: do_dpush = 1;
            7, 8: do_dpop = 1;
            9: {do_call, do_ret, do_reti, do_bm_toggle, do_psw_wr, do_dpush, do_dpop} = 7'($urandom);
            default: ;
        endcase
        irq_req     = ($urandom % 3 == 0);
        psw_wdata   = W'($urandom);
        dpush_data  = W'($urandom);
        ret_addr    = W'($urandom);
        call_target = W'($urandom);
        tick();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_in();
        model_reset();
        do_reset();

        // R12: data push and pop
        for (int i = 0; i < 3; i++) begin
            do_dpush = 1; dpush_data = W'(16'hA000 + i); tick();
        end
        do_dpop = 1; tick();

        // R7 then R6: full status write, toggles
        do_psw_wr = 1; psw_wdata = 16'h00F3; tick();
        do_bm_toggle = 1; tick();
        do_bm_toggle = 1; tick();

        // R8: call and request together; call wins, irq next free cycle (R4)
        do_call = 1; irq_req = 1; ret_addr = 16'h0101; call_target = 16'h0400; tick();
        irq_req = 1; ret_addr = 16'h0402; tick();
        // R8: enable now clear, held request is masked
        irq_req = 1; tick();
        // R5: return from interrupt restores status and counter
        do_reti = 1; tick();
        // R3: plain return leaves data stack alone
        do_ret = 1; tick();

        // R9: coinciding strobes, priority order
        do_ret = 1; do_call = 1; call_target = 16'h0777; tick();
        do_call = 1; do_psw_wr = 1; psw_wdata = 16'h0001; ret_addr = 16'h0055; call_target = 16'h0200; tick();
        do_bm_toggle = 1; do_dpush = 1; dpush_data = 16'h1234; tick();

        // R11: underflow on both stacks
        do_reset();
        do_ret = 1; tick();
        do_reti = 1; tick();
        do_dpop = 1; tick();

        // R10: fill both stacks past capacity
        do_reset();
        for (int i = 0; i < D + 2; i++) begin
            do_dpush = 1; dpush_data = W'(i * 3 + 1); tick();
        end
        for (int i = 0; i < D + 2; i++) begin
            do_call = 1; ret_addr = W'(i + 16'h0800); call_target = W'(i); tick();
        end
        // R4 against full stacks
        do_psw_wr = 1; psw_wdata = 16'h0003; tick();
        irq_req = 1; ret_addr = 16'h0999; tick();
        // flags stay set (R10)
        do_dpop = 1; tick();

        // Random phases
        for (int p = 0; p < 4; p++) begin
            do_reset();
            for (int i = 0; i < 2500; i++) rand_cycle();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule